// File: doc/BRIEF.md
# GPIO Register File with Set/Clear Aliases

This block is the software-facing register front-end of a 40-pin GPIO controller. It sits on an APB-style slave port, decodes a 4 KB word-addressed window and keeps the output-value and output-enable registers for two banks: pins 0 to 31 and pins 32 and up. Each of these registers can be written three ways: a plain write replaces it, a set alias ORs the written mask into it, and a clear alias removes the written mask bits. Firmware can therefore change single pins without a read-modify-write race.

The block also returns the pin levels, sampled through one register stage, and a strap word taken from an input port. It stores one configuration word per pin and two arrays of select words: input-select and output-select. These arrays are exported in parallel to the signal-routing logic. Interrupt status belongs to a separate interrupt unit. This block forwards status write, set and clear strobes to that unit, and reads back its status words and its four per-CPU words for each bank. Only full-word, word-aligned accesses take effect. Any other access is dropped without notice and reads as zero.

Top module: `gpio_regfile`

## Requirements
- R1: After reset, all output-value, output-enable, pin-configuration and select words are 0, and reading any of them returns 0.
- R2: A full-word write to a plain register address replaces it: output value bank 0 at 0x04 and bank 1 at 0x10, output enable bank 0 at 0x20 and bank 1 at 0x2C. The new value appears on `gpio_out`/`gpio_oe` and on read-back.
- R3: For each plain register at address A, the set alias at A+4 ORs the write data into the register, and the clear alias at A+8 ANDs the register with the inverted write data. Reading an alias address returns 0.
- R4: Bank 1 registers keep only bits NUM_PINS-33..0 (7..0 by default). Data bits above that are dropped and read back as 0.
- R5: A read of 0x3C returns input pins 31..0 and a read of 0x40 returns the upper input pins. Both reflect `pin_in` as it stood one clock earlier. A read of 0x38 returns `strap_in`. Writes to these three addresses change nothing.
- R6: A full-word write to 0x44/0x48/0x4C (bank 0) or to 0x50/0x54/0x58 (bank 1) pulses `stat_wr_valid` in the access cycle. It carries `stat_wr_bank`, `stat_wr_op` (0 plain, 1 set, 2 clear) and the data, which is masked to the bank width for bank 1. A read of 0x44 or 0x50 returns the status input of that bank, masked for bank 1.
- R7: Per-CPU status words are read at 0x60, 0x64, 0x68, 0x6C for bank 0 and at 0x74, 0x78, 0x7C, 0x80 for bank 1. They map to elements 0..3 of `cpu_stat_b0` and `cpu_stat_b1`. Bank 1 values are masked to the bank width.
- R8: Pin configuration word i is at 0x88 + 4*i for i from 0 to NUM_PINS-1. It can be read and written and is exported on `pin_cfg[i]`.
- R9: Input-select word i is at 0x130 + 4*i and output-select word i is at 0x530 + 4*i. Both can be read and written and are exported on `in_sel[i]` and `out_sel[i]`.
- R10: An access whose address is not a multiple of 4, or whose `psize` is not 2 (word), changes no register, raises no status strobe and reads as 0.
- R11: An access to an address outside every mapped register, for example 0x00, 0x5C, 0x84, 0x128 or 0x930, reads 0 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address in the window |
| psize | input | 2 | Access size: 0 byte, 1 half, 2 word |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pin_in | input | NUM_PINS | Pad input levels |
| strap_in | input | 32 | Strap value returned at 0x38 |
| gpio_out | output | NUM_PINS | Output-value registers |
| gpio_oe | output | NUM_PINS | Output-enable registers |
| pin_cfg | output | NUM_PINS x 32 | Per-pin configuration words |
| in_sel | output | NUM_IN_SEL x 32 | Input-select words |
| out_sel | output | NUM_OUT_SEL x 32 | Output-select words |
| stat_wr_valid | output | 1 | Status write strobe to the interrupt unit |
| stat_wr_bank | output | 1 | Bank of the status write |
| stat_wr_op | output | 2 | 0 plain, 1 set, 2 clear |
| stat_wr_data | output | 32 | Status write data |
| stat_b0 | input | 32 | Interrupt status, bank 0 |
| stat_b1 | input | 32 | Interrupt status, bank 1 |
| cpu_stat_b0 | input | 4 x 32 | Per-CPU words, bank 0 |
| cpu_stat_b1 | input | 4 x 32 | Per-CPU words, bank 1 |

## Verification
The bench probes the edges of every address range: the first and last pin-configuration words, and the last input-select word next to the first output-select word. An off-by-one in range decode would move a write into the neighbouring array or drop it. Alias writes use masks that overlap bits already set, so a set treated as a plain write, or a clear that keeps the mask instead of removing it, yields a visibly wrong value. Misaligned and sub-word writes to live registers and to the status addresses must leave the outputs unchanged and raise no strobe; a decoder that ignored `psize` or the low address bits would corrupt the registers. Bank 1 writes carry ones in the upper bits, which catches a design that keeps or echoes those bits.

// File: rtl/gpio_rf_pkg.sv
`timescale 1ns/1ps
// Shared types and fixed window layout for the GPIO register file.
package gpio_rf_pkg;
    localparam int unsigned IDX_W = 9;          // word index width, arrays up to 512 deep
    localparam logic [1:0]  SIZE_WORD = 2'd2;    // psize code of a full-word access
    localparam logic [11:0] PCFG_BASE = 12'h088;
    localparam logic [11:0] ISEL_BASE = 12'h130;
    localparam logic [11:0] OSEL_BASE = 12'h530;

    typedef enum logic [3:0] {
        RG_NONE, RG_OUT, RG_OEN, RG_STRAP, RG_IN, RG_STAT, RG_CPU,
        RG_PCFG, RG_ISEL, RG_OSEL
    } region_e;

    // Order matches the address slot within a plain/set/clear triplet.
    typedef enum logic [1:0] {OP_WR = 2'd0, OP_SET = 2'd1, OP_CLR = 2'd2} op_e;

    typedef struct packed {
        region_e           region;
        logic              bank;
        op_e               op;
        logic [IDX_W-1:0]  idx;
    } dec_t;
endpackage

// File: rtl/gpio_rf_decode.sv
`timescale 1ns/1ps
// Address decoder: maps a byte address and access size to a region, bank,
// write operation and word index. Assumes NUM_PINS > 32 and the array depths
// fit in IDX_W bits. Bad size or alignment yields RG_NONE.
module gpio_rf_decode
    import gpio_rf_pkg::*;
#(
    parameter int NUM_PINS    = 40,
    parameter int NUM_IN_SEL  = 256,
    parameter int NUM_OUT_SEL = 256
) (
    input  logic [11:0] addr,
    input  logic [1:0]  size,
    output dec_t        dec
);
    localparam logic [11:0] PCFG_LAST = PCFG_BASE + 12'(4 * (NUM_PINS - 1));
    localparam logic [11:0] ISEL_LAST = ISEL_BASE + 12'(4 * (NUM_IN_SEL - 1));
    localparam logic [11:0] OSEL_LAST = OSEL_BASE + 12'(4 * (NUM_OUT_SEL - 1));

    function automatic logic [1:0] slot(input logic [11:0] a, input logic [11:0] base);
        logic [11:0] d;
        d = (a - base) >> 2;
        return d[1:0];
    endfunction

    function automatic logic [IDX_W-1:0] widx(input logic [11:0] a, input logic [11:0] base);
        logic [11:0] d;
        d = (a - base) >> 2;
        return d[IDX_W-1:0];
    endfunction

    // Decode one access into its target.
    always_comb begin
        dec = '{region: RG_NONE, bank: 1'b0, op: OP_WR, idx: '0};
        if (addr[1:0] == 2'b00 && size == SIZE_WORD) begin
            case (addr)
                12'h004, 12'h008, 12'h00C: begin dec.region = RG_OUT;  dec.op = op_e'(slot(addr, 12'h004)); end
                12'h010, 12'h014, 12'h018: begin dec.region = RG_OUT;  dec.bank = 1'b1; dec.op = op_e'(slot(addr, 12'h010)); end
                12'h020, 12'h024, 12'h028: begin dec.region = RG_OEN;  dec.op = op_e'(slot(addr, 12'h020)); end
                12'h02C, 12'h030, 12'h034: begin dec.region = RG_OEN;  dec.bank = 1'b1; dec.op = op_e'(slot(addr, 12'h02C)); end
                12'h038:                   dec.region = RG_STRAP;
                12'h03C:                   dec.region = RG_IN;
                12'h040:                   begin dec.region = RG_IN; dec.bank = 1'b1; end
                12'h044, 12'h048, 12'h04C: begin dec.region = RG_STAT; dec.op = op_e'(slot(addr, 12'h044)); end
                12'h050, 12'h054, 12'h058: begin dec.region = RG_STAT; dec.bank = 1'b1; dec.op = op_e'(slot(addr, 12'h050)); end
                12'h060, 12'h064, 12'h068, 12'h06C: begin
                    dec.region = RG_CPU; dec.idx = IDX_W'(slot(addr, 12'h060));
                end
                12'h074, 12'h078, 12'h07C, 12'h080: begin
                    dec.region = RG_CPU; dec.bank = 1'b1; dec.idx = IDX_W'(slot(addr, 12'h074));
                end
                default: begin
                    if (addr >= PCFG_BASE && addr <= PCFG_LAST) begin
                        dec.region = RG_PCFG; dec.idx = widx(addr, PCFG_BASE);
                    end else if (addr >= ISEL_BASE && addr <= ISEL_LAST) begin
                        dec.region = RG_ISEL; dec.idx = widx(addr, ISEL_BASE);
                    end else if (addr >= OSEL_BASE && addr <= OSEL_LAST) begin
                        dec.region = RG_OSEL; dec.idx = widx(addr, OSEL_BASE);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/gpio_rf_alias_reg.sv
`timescale 1ns/1ps
// One register with plain, set and clear write operations.
// Assumes the caller presents at most one operation per cycle.
module gpio_rf_alias_reg
    import gpio_rf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  op_e          op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Apply replace, OR-in or mask-out on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (we) begin
            case (op)
                OP_WR:   q <= wdata;
                OP_SET:  q <= q | wdata;
                OP_CLR:  q <= q & ~wdata;
                default: q <= q;
            endcase
        end
    end
endmodule

// File: rtl/gpio_rf_word_array.sv
`timescale 1ns/1ps
// Array of 32-bit configuration words, one shared index for read and write,
// all words exported in parallel. Assumes idx < DEPTH when we is high.
module gpio_rf_word_array
    import gpio_rf_pkg::*;
#(
    parameter int DEPTH = 40
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [IDX_W-1:0]       idx,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    output logic [DEPTH-1:0][31:0] words
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        // Store word i when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                           words[i] <= '0;
            else if (we && idx == IDX_W'(i))      words[i] <= wdata;
        end
    end

    // Select the addressed word for read.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++)
            if (idx == IDX_W'(i)) rdata = words[i];
    end
endmodule

// File: rtl/gpio_regfile.sv
`timescale 1ns/1ps
// GPIO register file: APB-style slave holding the output and enable registers
// with set/clear aliases, pin configuration and select arrays. It samples pin
// inputs and forwards status writes to an external interrupt unit.
// Assumes NUM_PINS in 33..64; only full-word aligned accesses take effect.
module gpio_regfile
    import gpio_rf_pkg::*;
#(
    parameter int NUM_PINS    = 40,
    parameter int NUM_IN_SEL  = 256,
    parameter int NUM_OUT_SEL = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         psel,
    input  logic                         penable,
    input  logic                         pwrite,
    input  logic [11:0]                  paddr,
    input  logic [1:0]                   psize,
    input  logic [31:0]                  pwdata,
    output logic [31:0]                  prdata,
    input  logic [NUM_PINS-1:0]          pin_in,
    input  logic [31:0]                  strap_in,
    output logic [NUM_PINS-1:0]          gpio_out,
    output logic [NUM_PINS-1:0]          gpio_oe,
    output logic [NUM_PINS-1:0][31:0]    pin_cfg,
    output logic [NUM_IN_SEL-1:0][31:0]  in_sel,
    output logic [NUM_OUT_SEL-1:0][31:0] out_sel,
    output logic                         stat_wr_valid,
    output logic                         stat_wr_bank,
    output logic [1:0]                   stat_wr_op,
    output logic [31:0]                  stat_wr_data,
    input  logic [31:0]                  stat_b0,
    input  logic [31:0]                  stat_b1,
    input  logic [3:0][31:0]             cpu_stat_b0,
    input  logic [3:0][31:0]             cpu_stat_b1
);
    localparam int          HI_W    = NUM_PINS - 32;
    localparam logic [31:0] HI_MASK = 32'((64'd1 << HI_W) - 64'd1);

    dec_t                dec;
    logic                acc, wr_fire;
    logic [NUM_PINS-1:0] pin_q;
    logic [1:0][31:0]    out_rd, oen_rd;
    logic [31:0]         pcfg_rd, isel_rd, osel_rd, rsel;

    assign acc     = psel && penable;
    assign wr_fire = acc && pwrite;

    gpio_rf_decode #(
        .NUM_PINS(NUM_PINS), .NUM_IN_SEL(NUM_IN_SEL), .NUM_OUT_SEL(NUM_OUT_SEL)
    ) u_dec (.addr(paddr), .size(psize), .dec(dec));

    // Two banks of output-value and output-enable registers.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam int BW = (b == 0) ? 32 : HI_W;
        logic [BW-1:0] out_q, oen_q;

        gpio_rf_alias_reg #(.W(BW)) u_out (
            .clk(clk), .rst_n(rst_n),
            .we(wr_fire && dec.region == RG_OUT && dec.bank == 1'(b)),
            .op(dec.op), .wdata(pwdata[BW-1:0]), .q(out_q));

        gpio_rf_alias_reg #(.W(BW)) u_oen (
            .clk(clk), .rst_n(rst_n),
            .we(wr_fire && dec.region == RG_OEN && dec.bank == 1'(b)),
            .op(dec.op), .wdata(pwdata[BW-1:0]), .q(oen_q));

        assign gpio_out[b*32 +: BW] = out_q;
        assign gpio_oe[b*32 +: BW]  = oen_q;
        assign out_rd[b]            = 32'(out_q);
        assign oen_rd[b]            = 32'(oen_q);
    end

    gpio_rf_word_array #(.DEPTH(NUM_PINS)) u_pcfg (
        .clk(clk), .rst_n(rst_n), .we(wr_fire && dec.region == RG_PCFG),
        .idx(dec.idx), .wdata(pwdata), .rdata(pcfg_rd), .words(pin_cfg));

    gpio_rf_word_array #(.DEPTH(NUM_IN_SEL)) u_isel (
        .clk(clk), .rst_n(rst_n), .we(wr_fire && dec.region == RG_ISEL),
        .idx(dec.idx), .wdata(pwdata), .rdata(isel_rd), .words(in_sel));

    gpio_rf_word_array #(.DEPTH(NUM_OUT_SEL)) u_osel (
        .clk(clk), .rst_n(rst_n), .we(wr_fire && dec.region == RG_OSEL),
        .idx(dec.idx), .wdata(pwdata), .rdata(osel_rd), .words(out_sel));

    // Sample pad levels once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_in;
    end

    // Forward status writes to the interrupt unit in the access cycle.
    assign stat_wr_valid = wr_fire && dec.region == RG_STAT;
    assign stat_wr_bank  = dec.bank;
    assign stat_wr_op    = dec.op;
    assign stat_wr_data  = dec.bank ? (pwdata & HI_MASK) : pwdata;

    // Read mux; alias addresses read as zero.
    always_comb begin
        rsel = '0;
        case (dec.region)
            RG_OUT:   rsel = (dec.op == OP_WR) ? out_rd[dec.bank] : '0;
            RG_OEN:   rsel = (dec.op == OP_WR) ? oen_rd[dec.bank] : '0;
            RG_STRAP: rsel = strap_in;
            RG_IN:    rsel = dec.bank ? 32'(pin_q[NUM_PINS-1:32]) : pin_q[31:0];
            RG_STAT:  rsel = (dec.op != OP_WR) ? '0 : dec.bank ? (stat_b1 & HI_MASK) : stat_b0;
            RG_CPU:   rsel = dec.bank ? (cpu_stat_b1[dec.idx[1:0]] & HI_MASK)
                                      : cpu_stat_b0[dec.idx[1:0]];
            RG_PCFG:  rsel = pcfg_rd;
            RG_ISEL:  rsel = isel_rd;
            RG_OSEL:  rsel = osel_rd;
            default:  rsel = '0;
        endcase
    end

    assign prdata = (acc && !pwrite) ? rsel : '0;
endmodule

// File: rtl/gpio_regfile_chk.sv
`timescale 1ns/1ps
// Property checker for gpio_regfile, attached by bind.
module gpio_regfile_chk #(
    parameter int NUM_PINS = 40
) (
    input logic                clk,
    input logic                rst_n,
    input logic                psel,
    input logic                penable,
    input logic                pwrite,
    input logic [11:0]         paddr,
    input logic [1:0]          psize,
    input logic [31:0]         pwdata,
    input logic [31:0]         prdata,
    input logic [NUM_PINS-1:0] gpio_out,
    input logic [NUM_PINS-1:0] gpio_oe,
    input logic                stat_wr_valid
);
    logic acc, bad, good_wr;
    assign acc     = psel && penable;
    assign bad     = (paddr[1:0] != 2'b00) || (psize != 2'd2);
    assign good_wr = acc && pwrite && !bad;

    // R2: registers move only on a write access.
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && pwrite) |=> ($stable(gpio_out) && $stable(gpio_oe)));

    // R3: set alias leaves every mask bit high.
    p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && paddr == 12'h008) |=> ((gpio_out[31:0] & $past(pwdata)) == $past(pwdata)));

    // R3: clear alias leaves every mask bit low.
    p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && paddr == 12'h00C) |=> ((gpio_out[31:0] & $past(pwdata)) == 32'd0));

    // R4: bank 1 read-back has nothing above the bank width.
    p_hi_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !pwrite && !bad && paddr == 12'h010) |-> ((prdata >> (NUM_PINS - 32)) == 32'd0));

    // R6: status strobe only during a write access.
    p_strobe_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr_valid |-> (acc && pwrite));

    // R10: bad accesses raise no strobe.
    p_bad_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && bad) |-> !stat_wr_valid);

    // R10: bad writes leave the outputs alone.
    p_bad_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pwrite && bad) |=> ($stable(gpio_out) && $stable(gpio_oe)));

    // R10: bad reads return zero.
    p_bad_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !pwrite && bad) |-> (prdata == 32'd0));
endmodule

bind gpio_regfile gpio_regfile_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .psize(psize), .pwdata(pwdata), .prdata(prdata),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .stat_wr_valid(stat_wr_valid));

// File: tb/test_gpio_regfile.sv
`timescale 1ns/1ps
module test_gpio_regfile;
    localparam int NP = 40, NI = 256, NO = 256;

    logic clk = 1'b0, rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = '0;
    logic [1:0] psize = 2'd2;
    logic [31:0] pwdata = '0, prdata;
    logic [NP-1:0] pin_in = '0, gpio_out, gpio_oe;
    logic [31:0] strap_in = 32'h0000_0012;
    logic [NP-1:0][31:0] pin_cfg;
    logic [NI-1:0][31:0] in_sel;
    logic [NO-1:0][31:0] out_sel;
    logic stat_wr_valid, stat_wr_bank;
    logic [1:0] stat_wr_op;
    logic [31:0] stat_wr_data;
    logic [31:0] stat_b0 = 32'hCAFE_0001, stat_b1 = 32'hFFFF_FF5A;
    logic [3:0][31:0] cpu_stat_b0 = {32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001};
    logic [3:0][31:0] cpu_stat_b1 = {32'hFFFF_FF84, 32'hFFFF_FF83, 32'hFFFF_FF82, 32'hFFFF_FF81};

    int checks = 0, fails = 0;
    logic [31:0] rd_q, sd_q;
    logic sv_q, sb_q;
    logic [1:0] so_q;

    always #4 clk = ~clk;

    gpio_regfile #(.NUM_PINS(NP), .NUM_IN_SEL(NI), .NUM_OUT_SEL(NO)) i_gpio_regfile (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .psize(psize), .pwdata(pwdata), .prdata(prdata),
        .pin_in(pin_in), .strap_in(strap_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .pin_cfg(pin_cfg), .in_sel(in_sel), .out_sel(out_sel),
        .stat_wr_valid(stat_wr_valid), .stat_wr_bank(stat_wr_bank),
        .stat_wr_op(stat_wr_op), .stat_wr_data(stat_wr_data),
        .stat_b0(stat_b0), .stat_b1(stat_b1),
        .cpu_stat_b0(cpu_stat_b0), .cpu_stat_b1(cpu_stat_b1));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus access; captures read data and status strobe in the access phase.
    task automatic bus(input bit wr, input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = wr; paddr = a; psize = sz; pwdata = d;
        @(negedge clk);
        penable = 1;
        #1;
        rd_q = prdata; sv_q = stat_wr_valid; sb_q = stat_wr_bank; so_q = stat_wr_op; sd_q = stat_wr_data;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d); bus(1, a, 2'd2, d); endtask
    task automatic rd32(input logic [11:0] a); bus(0, a, 2'd2, 32'h0); endtask

    task automatic t_reset;
        chk("R1 gpio_out", 64'(gpio_out), 0);
        chk("R1 gpio_oe", 64'(gpio_oe), 0);
        chk("R1 pin_cfg[5]", 64'(pin_cfg[5]), 0);
        chk("R1 out_sel[9]", 64'(out_sel[9]), 0);
        rd32(12'h004); chk("R1 read out0", 64'(rd_q), 0);
    endtask

    task automatic t_plain;
        wr32(12'h004, 32'hA5A5_1234);
        rd32(12'h004); chk("R2 read out0", 64'(rd_q), 64'hA5A5_1234);
        chk("R2 gpio_out lo", 64'(gpio_out[31:0]), 64'hA5A5_1234);
        wr32(12'h020, 32'hF0F0_F0F0);
        chk("R2 gpio_oe lo", 64'(gpio_oe[31:0]), 64'hF0F0_F0F0);
    endtask

    task automatic t_alias;
        wr32(12'h008, 32'h0000_00C3);
        chk("R3 set out0", 64'(gpio_out[31:0]), 64'hA5A5_12F7);
        wr32(12'h00C, 32'hA500_0004);
        rd32(12'h004); chk("R3 clear out0", 64'(rd_q), 64'h00A5_12F3);
        rd32(12'h008); chk("R3 alias read zero", 64'(rd_q), 0);
        wr32(12'h028, 32'hF000_0000);
        chk("R3 clear oe0", 64'(gpio_oe[31:0]), 64'h00F0_F0F0);
        wr32(12'h024, 32'h0000_000F);
        chk("R3 set oe0", 64'(gpio_oe[31:0]), 64'h00F0_F0FF);
    endtask

    task automatic t_bank1;
        wr32(12'h010, 32'hFFFF_FF3C);
        rd32(12'h010); chk("R4 read out1 masked", 64'(rd_q), 64'h3C);
        chk("R4 gpio_out hi", 64'(gpio_out[39:32]), 64'h3C);
        wr32(12'h014, 32'h0001_00C0);
        chk("R4 set out1", 64'(gpio_out[39:32]), 64'hFC);
        wr32(12'h018, 32'h0000_000C);
        chk("R4 clear out1", 64'(gpio_out[39:32]), 64'hF0);
        wr32(12'h02C, 32'h0000_01FF);
        rd32(12'h02C); chk("R4 read oe1 masked", 64'(rd_q), 64'hFF);
        chk("R4 low bank untouched", 64'(gpio_out[31:0]), 64'h00A5_12F3);
    endtask

    task automatic t_inputs;
        @(negedge clk); pin_in = 40'hA5_1234_5678;
        rd32(12'h03C); chk("R5 input lo", 64'(rd_q), 64'h1234_5678);
        rd32(12'h040); chk("R5 input hi", 64'(rd_q), 64'hA5);
        rd32(12'h038); chk("R5 strap", 64'(rd_q), 64'h12);
        wr32(12'h03C, 32'h0);
        wr32(12'h038, 32'hFFFF_FFFF);
        rd32(12'h03C); chk("R5 input write ignored", 64'(rd_q), 64'h1234_5678);
        rd32(12'h038); chk("R5 strap write ignored", 64'(rd_q), 64'h12);
        chk("R5 outputs unchanged", 64'(gpio_out), 64'hF0_00A5_12F3);
    endtask

    task automatic t_status;
        wr32(12'h044, 32'h0000_DEAD);
        chk("R6 plain strobe", {sv_q, sb_q, so_q, sd_q}, {1'b1, 1'b0, 2'd0, 32'h0000_DEAD});
        wr32(12'h054, 32'h0000_FFF1);
        chk("R6 set strobe bank1", {sv_q, sb_q, so_q, sd_q}, {1'b1, 1'b1, 2'd1, 32'h0000_00F1});
        wr32(12'h04C, 32'h0000_0003);
        chk("R6 clear strobe", {sv_q, sb_q, so_q, sd_q}, {1'b1, 1'b0, 2'd2, 32'h3});
        rd32(12'h044); chk("R6 read status0", 64'(rd_q), 64'hCAFE_0001);
        chk("R6 no strobe on read", 64'(sv_q), 0);
        rd32(12'h050); chk("R6 read status1", 64'(rd_q), 64'h5A);
        rd32(12'h048); chk("R6 alias read zero", 64'(rd_q), 0);
    endtask

    task automatic t_cpu;
        for (int i = 0; i < 4; i++) begin
            rd32(12'h060 + 12'(4 * i));
            chk($sformatf("R7 cpu bank0 word %0d", i), 64'(rd_q), 64'(cpu_stat_b0[i]));
            rd32(12'h074 + 12'(4 * i));
            chk($sformatf("R7 cpu bank1 word %0d", i), 64'(rd_q), 64'(cpu_stat_b1[i] & 32'hFF));
        end
    endtask

    task automatic t_pcfg;
        wr32(12'h088, 32'h1111_AAAA);
        wr32(12'h124, 32'h2222_BBBB);
        chk("R8 pin_cfg[0]", 64'(pin_cfg[0]), 64'h1111_AAAA);
        chk("R8 pin_cfg[39]", 64'(pin_cfg[39]), 64'h2222_BBBB);
        chk("R8 pin_cfg[38]", 64'(pin_cfg[38]), 0);
        rd32(12'h124); chk("R8 read cfg 39", 64'(rd_q), 64'h2222_BBBB);
    endtask

    task automatic t_sel;
        wr32(12'h130, 32'h0000_0101);
        wr32(12'h52C, 32'h0000_0202);
        wr32(12'h530, 32'h0000_0303);
        wr32(12'h92C, 32'h0000_0404);
        chk("R9 in_sel[0]", 64'(in_sel[0]), 64'h101);
        chk("R9 in_sel[255]", 64'(in_sel[255]), 64'h202);
        chk("R9 out_sel[0]", 64'(out_sel[0]), 64'h303);
        chk("R9 out_sel[255]", 64'(out_sel[255]), 64'h404);
        rd32(12'h52C); chk("R9 read in_sel 255", 64'(rd_q), 64'h202);
        rd32(12'h530); chk("R9 read out_sel 0", 64'(rd_q), 64'h303);
    endtask

    task automatic t_bad;
        bus(1, 12'h006, 2'd2, 32'h0);
        chk("R10 misaligned write", 64'(gpio_out), 64'hF0_00A5_12F3);
        bus(1, 12'h004, 2'd1, 32'h0);
        chk("R10 half write", 64'(gpio_out), 64'hF0_00A5_12F3);
        bus(1, 12'h020, 2'd0, 32'h0);
        chk("R10 byte write oe", 64'(gpio_oe), 64'hFF_00F0_F0FF);
        bus(0, 12'h004, 2'd0, 32'h0);
        chk("R10 byte read zero", 64'(rd_q), 0);
        bus(0, 12'h005, 2'd2, 32'h0);
        chk("R10 misaligned read zero", 64'(rd_q), 0);
        bus(1, 12'h045, 2'd2, 32'h1);
        chk("R10 misaligned status no strobe", 64'(sv_q), 0);
        bus(1, 12'h044, 2'd1, 32'h1);
        chk("R10 half status no strobe", 64'(sv_q), 0);
        bus(1, 12'h089, 2'd2, 32'hFFFF_FFFF);
        chk("R10 cfg untouched", 64'(pin_cfg[0]), 64'h1111_AAAA);
    endtask

    task automatic t_unmapped;
        wr32(12'h000, 32'hFFFF_FFFF);
        wr32(12'h05C, 32'hFFFF_FFFF);
        wr32(12'h084, 32'hFFFF_FFFF);
        wr32(12'h128, 32'hFFFF_FFFF);
        wr32(12'h930, 32'hFFFF_FFFF);
        chk("R11 outputs unchanged", 64'(gpio_out), 64'hF0_00A5_12F3);
        chk("R11 no strobe", 64'(sv_q), 0);
        chk("R11 cfg39 unchanged", 64'(pin_cfg[39]), 64'h2222_BBBB);
        chk("R11 out_sel255 unchanged", 64'(out_sel[255]), 64'h404);
        rd32(12'h000); chk("R11 read 0x000", 64'(rd_q), 0);
        rd32(12'h128); chk("R11 read 0x128", 64'(rd_q), 0);
        rd32(12'h930); chk("R11 read 0x930", 64'(rd_q), 0);
    endtask

    initial begin
        #(8 * 100000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_plain;
        t_alias;
        t_bank1;
        t_inputs;
        t_status;
        t_cpu;
        t_pcfg;
        t_sel;
        t_bad;
        t_unmapped;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule